// File: doc/BRIEF.md
# Instruction Candidate Tunneling Generator

This block sequences a depth-first walk over a fixed-size candidate instruction buffer for an external harness that runs each candidate and reports what it saw. After a start pulse it presents an all-zero buffer. It then waits for an observation giving the length the harness measured and an exception class code. Using that result, it picks the single byte to advance for the next candidate.

The walk follows what the observations say. When the length or exception class differs from the previous observation, the byte at the end of the newly measured instruction is advanced. When nothing changed, the same byte keeps being advanced, so displacement and immediate bytes that do not affect decoding are run through quickly. A byte that rolls over from its maximum value returns to zero and carries into the byte in front of it. The bytes behind the new position are cleared, and advancing continues from there. A carry out of the first byte ends the search.

Only one candidate is outstanding at a time. A new one is offered only after the observation for the previous one has been taken.

Top module: `tunnel_gen`

## Requirements
- R1: After reset, `cand_valid`, `done` and `len_err` are low. The cycle after `start`, `cand_valid` is high, `cand_data` is all zero and `done` is low.
- R2: When an observation is the first since `start`, or its clamped length or its exception class differs from the previous observation, the byte at index length−1 is advanced by one. Without a roll-over, that is the only byte of the next candidate that differs. Example: an all-zero candidate seen as 2 bytes long yields 00 01 00 … in the next candidate.
- R3: When length and exception class both equal the previous observation, the byte advanced is the one advanced last time (or the one a carry last landed on).
- R4: A byte at 0xFF rolls to 0x00 and carries into the byte in front of it, repeating while bytes are 0xFF. The byte that absorbs the carry becomes the active position. Every byte behind the original position is cleared.
- R5: A carry out of byte 0 raises `done` and drops `cand_valid`. Both hold until the next `start`.
- R6: An observed length of 0 or above 15 is treated as 15 and sets `len_err`. `len_err` stays set until the next `start`.
- R7: While `cand_valid` is high and `cand_ready` is low, `cand_data` is held. An `obs_valid` arriving when no candidate is outstanding has no effect.
- R8: After a candidate is accepted, `cand_valid` stays low until its observation is taken.
- R9: Byte i of the candidate (i = 0 is the first instruction byte) is on `cand_data[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: clear the buffer and begin a new search |
| cand_data | output | 120 | Current candidate, byte i at bits 8i+7..8i |
| cand_valid | output | 1 | Candidate offered |
| cand_ready | input | 1 | Harness takes the candidate |
| obs_valid | input | 1 | Observation strobe |
| obs_len | input | 4 | Observed length in bytes |
| obs_exc | input | 3 | Observed exception class code |
| done | output | 1 | Search finished |
| len_err | output | 1 | An out-of-range length was seen since start |

## Verification
The bench runs a full search against a synthetic harness whose answers depend on the first two bytes. Most first-byte values give a one-byte instruction, which tests plain stepping of byte 0. Multiples of 16 give two-byte forms, which sweep byte 1 all the way to roll-over. One value lengthens to four bytes at a single second-byte value, so a deep carry chain must land back on an unchanged length. Another reports length 0, which forces a clamped sweep from byte 14 down to byte 1. An exception-class change with an unchanged length tells a change in fault behaviour apart from a change in length. A stalled handshake and a stray observation strobe check that nothing advances outside the outstanding-candidate window.

// File: rtl/tun_pkg.sv
package tun_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } tun_state_e;
endpackage

// File: rtl/tun_len_clamp.sv
module tun_len_clamp #(
  parameter int NBYTES = 15,
  parameter int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic [LEN_W-1:0] raw_len,
  output logic [LEN_W-1:0] eff_len,
  output logic             out_of_range
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(NBYTES);

  assign out_of_range = (raw_len == '0) || (raw_len > MAX_LEN);
  assign eff_len      = out_of_range ? MAX_LEN : raw_len;
endmodule

// File: rtl/tun_step_unit.sv
module tun_step_unit
  import tun_pkg::*;
#(
  parameter int NBYTES = 15,
  parameter int IDX_W  = $clog2(NBYTES)
) (
  input  logic [NBYTES-1:0][BYTE_W-1:0] cur_buf,
  input  logic [IDX_W-1:0]              pos,
  output logic [NBYTES-1:0][BYTE_W-1:0] nxt_buf,
  output logic [IDX_W-1:0]              nxt_active,
  output logic                          rolled,
  output logic                          carry_out
);
  logic c;

  // Big-endian increment of bytes 0..pos; bytes past pos cleared on roll-over.
  always_comb begin
    c          = 1'b1;
    rolled     = (cur_buf[pos] == '1);
    nxt_active = '0;
    for (int i = NBYTES - 1; i >= 0; i--) begin
      if (i > int'(pos)) begin
        nxt_buf[i] = rolled ? '0 : cur_buf[i];
      end else if (c) begin
        nxt_buf[i] = cur_buf[i] + 1'b1;
        if (cur_buf[i] != '1) begin
          c          = 1'b0;
          nxt_active = IDX_W'(i);
        end
      end else begin
        nxt_buf[i] = cur_buf[i];
      end
    end
    carry_out = c;
  end
endmodule

// File: rtl/tunnel_gen.sv
module tunnel_gen
  import tun_pkg::*;
#(
  parameter int NBYTES = 15,
  parameter int EXC_W  = 3,
  parameter int LEN_W  = $clog2(NBYTES + 1),
  parameter int IDX_W  = $clog2(NBYTES),
  parameter int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [DATA_W-1:0] cand_data,
  output logic              cand_valid,
  input  logic              cand_ready,
  input  logic              obs_valid,
  input  logic [LEN_W-1:0]  obs_len,
  input  logic [EXC_W-1:0]  obs_exc,
  output logic              done,
  output logic              len_err
);
  tun_state_e                    state_q;
  logic [NBYTES-1:0][BYTE_W-1:0] cand_q;
  logic [NBYTES-1:0][BYTE_W-1:0] step_buf;
  logic [IDX_W-1:0]              active_q, step_active, pick_pos;
  logic [LEN_W-1:0]              prev_len_q, eff_len;
  logic [EXC_W-1:0]              prev_exc_q;
  logic                          have_prev_q, len_err_q;
  logic                          len_bad, step_carry;

  // Named events for the checker
  logic emit_fire, obs_fire, change_ev, wrap_ev;

  assign emit_fire = (state_q == ST_EMIT) && cand_ready;
  assign obs_fire  = (state_q == ST_WAIT) && obs_valid;

  tun_len_clamp #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_clamp (
    .raw_len      (obs_len),
    .eff_len      (eff_len),
    .out_of_range (len_bad)
  );

  assign change_ev = !have_prev_q || (eff_len != prev_len_q) || (obs_exc != prev_exc_q);
  assign pick_pos  = change_ev ? IDX_W'(eff_len - LEN_W'(1)) : active_q;

  tun_step_unit #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_step (
    .cur_buf    (cand_q),
    .pos        (pick_pos),
    .nxt_buf    (step_buf),
    .nxt_active (step_active),
    .rolled     (wrap_ev),
    .carry_out  (step_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cand_q      <= '0;
      active_q    <= '0;
      prev_len_q  <= '0;
      prev_exc_q  <= '0;
      have_prev_q <= 1'b0;
      len_err_q   <= 1'b0;
    end else if (start) begin
      state_q     <= ST_EMIT;
      cand_q      <= '0;
      active_q    <= '0;
      prev_len_q  <= '0;
      prev_exc_q  <= '0;
      have_prev_q <= 1'b0;
      len_err_q   <= 1'b0;
    end else if (emit_fire) begin
      state_q <= ST_WAIT;
    end else if (obs_fire) begin
      cand_q      <= step_buf;
      active_q    <= step_active;
      prev_len_q  <= eff_len;
      prev_exc_q  <= obs_exc;
      have_prev_q <= 1'b1;
      len_err_q   <= len_err_q | len_bad;
      state_q     <= step_carry ? ST_DONE : ST_EMIT;
    end
  end

  assign cand_data  = cand_q;
  assign cand_valid = (state_q == ST_EMIT);
  assign done       = (state_q == ST_DONE);
  assign len_err    = len_err_q;
endmodule

// File: rtl/tunnel_gen_checker.sv
module tunnel_gen_checker #(
  parameter int NBYTES = 15,
  parameter int LEN_W  = 4,
  parameter int DATA_W = NBYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DATA_W-1:0] cand_data,
  input logic              cand_valid,
  input logic              cand_ready,
  input logic [LEN_W-1:0]  obs_len,
  input logic              done,
  input logic              len_err,
  input logic              obs_fire,
  input logic              wrap_ev
);
  logic [DATA_W-1:0] last_data_q;
  logic [NBYTES-1:0] byte_diff;

  always_ff @(posedge clk) last_data_q <= cand_data;

  for (genvar g = 0; g < NBYTES; g++) begin : g_diff
    assign byte_diff[g] = (cand_data[8*g +: 8] != last_data_q[8*g +: 8]);
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cand_valid && (cand_data == '0) && !done);

  p_one_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    obs_fire && !wrap_ev && !start |=> $countones(byte_diff) == 1);

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && !cand_valid);

  p_len_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    obs_fire && (obs_len == '0) && !start |=> len_err);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready && !start |=> cand_valid && $stable(cand_data));

  p_single_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready && !start |=> !cand_valid);
endmodule

bind tunnel_gen tunnel_gen_checker #(.NBYTES(NBYTES), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .cand_data  (cand_data),
  .cand_valid (cand_valid),
  .cand_ready (cand_ready),
  .obs_len    (obs_len),
  .done       (done),
  .len_err    (len_err),
  .obs_fire   (obs_fire),
  .wrap_ev    (wrap_ev)
);

// File: tb/tunnel_gen_test.sv
module tunnel_gen_test;
  localparam int NB = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [119:0] cand_data;
  logic         cand_valid;
  logic         cand_ready = 1'b0;
  logic         obs_valid = 1'b0;
  logic [3:0]   obs_len = '0;
  logic [2:0]   obs_exc = '0;
  logic         done;
  logic         len_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tunnel_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cand_data(cand_data), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .obs_valid(obs_valid), .obs_len(obs_len), .obs_exc(obs_exc),
    .done(done), .len_err(len_err)
  );

  // Reference state
  logic [7:0] m [NB];
  int  cur_idx, prev_l, prev_e;
  bit  have_prev, m_done, m_lerr;
  string tag;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [119:0] packed_model();
    logic [119:0] v;
    for (int i = 0; i < NB; i++) v[8*i +: 8] = m[i];  // R9 byte placement
    return v;
  endfunction

  task automatic harness(output int l, output int e);
    logic [7:0] b0;
    b0 = m[0];
    if (b0 == 8'h00) begin l = 2; e = (m[1] >= 8'h80) ? 1 : 0; end
    else if (b0 == 8'h10) begin l = (m[1] == 8'h05) ? 4 : 2; e = 0; end
    else if (b0 == 8'h80) begin l = 0; e = 2; end
    else if (b0[3:0] == 4'h0) begin l = 2; e = int'(b0[7:6]); end
    else begin l = 1; e = int'(b0[7:6]); end
  endtask

  task automatic model_step(input int raw_l, input int e);
    int l, p, k;
    l = (raw_l < 1 || raw_l > NB) ? NB : raw_l;
    if (raw_l < 1 || raw_l > NB) m_lerr = 1'b1;
    if (!have_prev || l != prev_l || e != prev_e) begin p = l - 1; tag = "R2"; end
    else begin p = cur_idx; tag = "R3"; end
    have_prev = 1'b1; prev_l = l; prev_e = e;
    k = p;
    while (k >= 0 && m[k] == 8'hFF) begin m[k] = 8'h00; k--; end
    if (k < 0) m_done = 1'b1;
    else begin
      m[k] = m[k] + 8'h01;
      cur_idx = k;
      if (k < p) begin
        tag = "R4";
        for (int j = p + 1; j < NB; j++) m[j] = 8'h00;
      end
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < NB; i++) m[i] = 8'h00;
    cur_idx = 0; have_prev = 1'b0; m_done = 1'b0; m_lerr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int l, e, steps;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cand_valid && !done && !len_err, "R1 reset", {cand_valid, done, len_err}, 3'b000);

    do_start();
    check(cand_valid && cand_data == '0, "R1 first candidate", cand_data, '0);

    // R7: stall with ready low, stray observation while nothing outstanding
    obs_valid = 1'b1; obs_len = 4'd5; obs_exc = 3'd3;
    @(negedge clk);
    obs_valid = 1'b0;
    @(negedge clk);
    check(cand_valid && cand_data == '0, "R7 stall and stray strobe", cand_data, '0);

    steps = 0;
    while (!m_done) begin
      check(cand_valid && cand_data == packed_model(), tag, cand_data, packed_model());
      cand_ready = 1'b1;
      @(negedge clk);
      cand_ready = 1'b0;
      if (steps < 8) check(!cand_valid, "R8 no second candidate", cand_valid, 1'b0);
      harness(l, e);
      obs_valid = 1'b1; obs_len = 4'(l); obs_exc = 3'(e);
      @(negedge clk);
      obs_valid = 1'b0;
      model_step(l, e);
      if (steps == 0)
        check(cand_data == 120'h0100, "R2 second candidate 00 01", cand_data, 120'h0100);
      if (m_lerr && m[0] == 8'h80 && steps < 4200)
        check(len_err, "R6 clamp flag", len_err, 1'b1);
      steps++;
    end

    check(done && !cand_valid, "R5 done on byte0 carry", {done, cand_valid}, 2'b10);
    repeat (3) @(negedge clk);
    check(done && !cand_valid, "R5 done holds", {done, cand_valid}, 2'b10);
    check(len_err, "R6 sticky until start", len_err, 1'b1);

    do_start();
    check(!len_err && !done, "R6 cleared by start", {len_err, done}, 2'b00);
    check(cand_valid && cand_data == '0, "R1 restart zero", cand_data, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule